// File: doc/BRIEF.md
# Register-Access Command Framer for a Serial MAC-PHY Link

This block turns a register read or write request into the word sequence of a control transaction on a full-duplex serial link, and then checks what comes back. A request carries a 4-bit memory-map selector, a 16-bit register address, a read/write flag and a count of consecutive registers. The count may be 1 to `MAX_REGS`, which is 128 by default. The block sends a command header with odd parity. For a write it then sends the data words, which it pulls one at a time by index. For a read it sends zero words in those slots. A final pad word ends the transaction.

The pin-level shifter sits behind a word handshake. When `link_valid` and `link_ready` are both high, one 32-bit word leaves on `link_tx` and the word received in the same slot is taken from `link_rx`. Bits 31:24 of each word are the first byte on the wire. The far end echoes everything one word late. A write is therefore confirmed by comparing every echoed word with the word sent one slot before it. A read confirms only the echoed header, and the register values follow it. Read values come out one per cycle with a strobe and an index. The end of a transaction is marked by a one-cycle `done` pulse together with `fail`.

Top module: `regx_cmd_framer`

## Requirements
- R1: The header (slot 0) has bit 31 = 0, bit 30 = 0, bit 29 = 1 for write / 0 for read, bit 28 = 0, bits 27:24 = selector, bits 23:8 = address, bits 7:1 = count minus one.
- R2: Header bit 0 makes the XOR of all 32 header bits equal 1 (odd parity).
- R3: An accepted request with count N sends exactly N+2 words. Slot 0 is the header. Slots 1..N carry the write data (index = slot-1) for a write and zero for a read. Slot N+1 is a zero pad word.
- R4: For a write, the received words in slots 1..N+1 must equal the words sent in slots 0..N. Any mismatch makes `fail` high with `done`.
- R5: For a read, only the slot-1 received word is compared (against the header). The received words in slot 0 and in slots 2..N+1 never cause `fail`.
- R6: For a read whose header echo matches, the received word of slot k (2 ≤ k ≤ N+1) appears on `rd_data` with `rd_idx` = k-2 and `rd_valid` high for one cycle, on the cycle after that slot's handshake. After a header mismatch, no `rd_valid` is given.
- R7: A request with count 0 or count above `MAX_REGS` sends no word and leaves `busy` low. It produces `done` and `fail` high on the next cycle.
- R8: `busy` rises the cycle after an accepted request and falls in the cycle in which `done` pulses for one cycle. Requests made while `busy` is high are ignored.
- R9: While `link_valid` is high and `link_ready` is low, the transaction does not advance and `link_tx` holds its value.
- R10: `wr_idx` gives the index of the write data word that is on `link_tx` in the current slot, and `wr_word` is sampled in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 4 | Memory-map selector |
| req_addr | input | 16 | First register address |
| req_count | input | CNT_W | Number of registers |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| fail | output | 1 | Error qualifier, valid with done |
| link_valid | output | 1 | Word offered to the link |
| link_ready | input | 1 | Link takes the word this cycle |
| link_tx | output | 32 | Word to send |
| link_rx | input | 32 | Word received in the same slot |
| wr_idx | output | LEN_W | Index of the write word wanted |
| wr_word | input | 32 | Write data for wr_idx |
| rd_valid | output | 1 | Read word strobe |
| rd_idx | output | LEN_W | Read word index |
| rd_data | output | 32 | Read word |

## Verification
The assertions assume the link never withdraws a slot once it is offered: `link_rx` only matters in a handshake cycle, and `wr_word` follows `wr_idx` without delay. The bench keeps to this. It drives `link_rx` and `link_ready` at the falling edge from a slave model that replays its own record of past sent words one slot late. `wr_word` is a continuous lookup on `wr_idx`, and stalls follow a fixed pattern so that the held-word check has a known window. Requests are raised only at falling edges and for one cycle. The one exception is a deliberate request made while busy.

// File: rtl/regx_pkg.sv
package regx_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 4;
  localparam int ADR_W  = 16;
  localparam int LENF_W = 7;

  typedef enum logic {ST_IDLE, ST_RUN} seq_e;
endpackage

// File: rtl/regx_hdr_build.sv
module regx_hdr_build
  import regx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              is_write,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADR_W-1:0]  addr,
  input  logic [CNT_W-1:0]  count,
  output logic [WORD_W-1:0] hdr
);
  logic [CNT_W-1:0]  cnt_m1;
  logic [LENF_W-1:0] len_f;
  logic [WORD_W-1:1] body;

  always_comb begin
    cnt_m1 = count - CNT_W'(1);
    len_f  = LENF_W'(cnt_m1);
    body   = {1'b0, 1'b0, is_write, 1'b0, sel, addr, len_f};
    hdr    = {body, ~^body};
  end
endmodule

// File: rtl/regx_echo_chk.sv
module regx_echo_chk
  import regx_pkg::*;
(
  input  logic              step,
  input  logic              at_zero,
  input  logic              at_one,
  input  logic              is_write,
  input  logic [WORD_W-1:0] expect_w,
  input  logic [WORD_W-1:0] got_w,
  output logic              miss
);
  logic cmp_en;

  always_comb begin
    cmp_en = step && !at_zero && (is_write || at_one);
    miss   = cmp_en && (got_w != expect_w);
  end
endmodule

// File: rtl/regx_cmd_framer.sv
module regx_cmd_framer
  import regx_pkg::*;
#(
  parameter int MAX_REGS = 128,
  parameter int CNT_W    = $clog2(MAX_REGS) + 1,
  parameter int LEN_W    = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_sel,
  input  logic [15:0]       req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              link_valid,
  input  logic              link_ready,
  output logic [31:0]       link_tx,
  input  logic [31:0]       link_rx,
  output logic [LEN_W-1:0]  wr_idx,
  input  logic [31:0]       wr_word,
  output logic              rd_valid,
  output logic [LEN_W-1:0]  rd_idx,
  output logic [31:0]       rd_data
);
  localparam int SLOT_W = $clog2(MAX_REGS + 2);

  seq_e              st_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] cnt_q;
  logic [WORD_W-1:0] hdr_q;
  logic [WORD_W-1:0] prev_q;
  logic              wr_q;
  logic              err_q;
  logic              done_q;
  logic              fail_q;
  logic              rdv_q;
  logic [LEN_W-1:0]  rdi_q;
  logic [WORD_W-1:0] rdd_q;

  logic [WORD_W-1:0] hdr_w;
  logic              count_ok;
  logic              step;
  logic              last;
  logic              miss;
  logic [WORD_W-1:0] tx_w;

  regx_hdr_build #(.CNT_W(CNT_W)) u_hdr (
    .is_write (req_write),
    .sel      (req_sel),
    .addr     (req_addr),
    .count    (req_count),
    .hdr      (hdr_w)
  );

  regx_echo_chk u_chk (
    .step     (step),
    .at_zero  (slot_q == '0),
    .at_one   (slot_q == SLOT_W'(1)),
    .is_write (wr_q),
    .expect_w (prev_q),
    .got_w    (link_rx),
    .miss     (miss)
  );

  always_comb begin
    count_ok = (req_count != '0) && (int'(req_count) <= MAX_REGS);
    step     = (st_q == ST_RUN) && link_ready;
    last     = (slot_q == cnt_q + SLOT_W'(1));
    if (slot_q == '0)                       tx_w = hdr_q;
    else if (wr_q && (slot_q <= cnt_q))     tx_w = wr_word;
    else                                    tx_w = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      prev_q <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      rdv_q  <= 1'b0;
      rdi_q  <= '0;
      rdd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      rdv_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (count_ok) begin
              hdr_q  <= hdr_w;
              wr_q   <= req_write;
              cnt_q  <= SLOT_W'(req_count);
              slot_q <= '0;
              err_q  <= 1'b0;
              st_q   <= ST_RUN;
            end else begin
              done_q <= 1'b1;
              fail_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (step) begin
            prev_q <= tx_w;
            slot_q <= slot_q + SLOT_W'(1);
            if (miss) err_q <= 1'b1;
            if (!wr_q && (slot_q >= SLOT_W'(2)) && !err_q) begin
              rdv_q <= 1'b1;
              rdi_q <= LEN_W'(slot_q - SLOT_W'(2));
              rdd_q <= link_rx;
            end
            if (last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              fail_q <= err_q | miss;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st_q == ST_RUN);
  assign done       = done_q;
  assign fail       = fail_q;
  assign link_valid = (st_q == ST_RUN);
  assign link_tx    = tx_w;
  assign wr_idx     = LEN_W'(slot_q - SLOT_W'(1));
  assign rd_valid   = rdv_q;
  assign rd_idx     = rdi_q;
  assign rd_data    = rdd_q;

  // R2 / R1: header slot carries odd parity and the control marker
  assert_hdr_parity_R2: assert property (@(posedge clk) disable iff (rst)
    (link_valid && slot_q == '0) |-> ((^link_tx) == 1'b1 && !link_tx[31]));

  // R7: bad count gives done with fail and no transaction
  assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !count_ok) |=> (done && fail && !busy));

  // R9: stalled slot keeps its word
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (link_valid && !link_ready) |=> (link_valid && $stable(link_tx)));

  // R8: done is a lone pulse outside busy
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: read words never appear for a write transaction
  assert_rd_read_only_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !wr_q);
endmodule

// File: tb/regx_cmd_framer_bench.sv
`timescale 1ns/1ps
module regx_cmd_framer_bench;
  localparam int MAXR = 128;
  localparam int CW   = 8;
  localparam int LW   = 7;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write;
  logic [3:0]    req_sel;
  logic [15:0]   req_addr;
  logic [CW-1:0] req_count;
  logic          busy, done, fail, link_valid, link_ready;
  logic [31:0]   link_tx, link_rx, wr_word, rd_data;
  logic [LW-1:0] wr_idx, rd_idx;
  logic          rd_valid;

  logic [31:0] wbuf [0:MAXR-1];
  logic [31:0] rdv  [0:MAXR-1];
  logic [31:0] sent [0:MAXR+3];

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign wr_word = wbuf[wr_idx];

  regx_cmd_framer #(.MAX_REGS(MAXR)) u_regx_cmd_framer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_addr(req_addr), .req_count(req_count),
    .busy(busy), .done(done), .fail(fail), .link_valid(link_valid),
    .link_ready(link_ready), .link_tx(link_tx), .link_rx(link_rx),
    .wr_idx(wr_idx), .wr_word(wr_word), .rd_valid(rd_valid),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_hdr(input bit wr, input logic [3:0] sel,
                                          input logic [15:0] adr, input int n);
    logic [30:0] b;
    logic [6:0]  l;
    l = 7'(n - 1);
    b = {1'b0, wr, 1'b0, sel, adr, l};
    return {1'b0, b[29:0], ~^b};
  endfunction

  task automatic run_xfer(input bit wr, input logic [3:0] sel, input logic [15:0] adr,
                          input int n, input int corrupt, input bit stall, input bit poke);
    int slot = 0, cyc = 0, rd_cnt = 0;
    bit got_done = 0, got_fail = 0, hs, exp_fail;
    logic [31:0] held;
    bit held_v = 0;
    for (int i = 0; i < MAXR; i++) begin
      wbuf[i] = 32'h1000_0000 + i * 32'h0101_0003 + n;
      rdv[i]  = 32'hC000_0000 ^ (i * 32'h0003_0507);
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_sel = sel; req_addr = adr; req_count = CW'(n);
    @(negedge clk);
    req_valid = 0;
    chk("R8 busy after accept", {31'b0, busy}, 32'd1);
    while (!got_done && cyc < 3000) begin
      if (held_v) begin
        chk("R9 held word", link_tx, held);
        held_v = 0;
      end
      if (rd_valid) begin
        chk("R6 rd_idx", {25'b0, rd_idx}, rd_cnt);
        chk("R6 rd_data", rd_data, rdv[rd_idx]);
        rd_cnt++;
      end
      if (done) begin
        got_done = 1; got_fail = fail;
        break;
      end
      link_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (slot == 0) link_rx = 32'hA5A5_0F0F;
      else if (wr || slot == 1) link_rx = sent[slot-1] ^ ((slot == corrupt) ? 32'h10 : 32'h0);
      else link_rx = rdv[slot-2];
      req_valid = poke && (cyc == 2);
      if (req_valid) begin
        req_write = ~wr; req_sel = sel ^ 4'h1; req_addr = ~adr; req_count = 1;
      end
      hs = link_valid && link_ready;
      if (hs) begin
        sent[slot] = link_tx;
        if (wr && slot >= 1 && slot <= n)
          chk("R10 wr_idx", {25'b0, wr_idx}, slot - 1);
      end
      if (link_valid && !link_ready) begin held = link_tx; held_v = 1; end
      @(negedge clk);
      req_valid = 0;
      if (hs) slot++;
      cyc++;
    end
    link_ready = 0;
    chk("R8 done seen", {31'b0, got_done}, 32'd1);
    chk("R8 busy low at done", {31'b0, busy}, 32'd0);
    chk("R3 word count", slot, n + 2);
    chk("R1 R2 header", sent[0], exp_hdr(wr, sel, adr, n));
    for (int k = 1; k <= n; k++)
      chk("R3 body word", sent[k], wr ? wbuf[k-1] : 32'h0);
    chk("R3 pad word", sent[n+1], 32'h0);
    exp_fail = wr ? (corrupt >= 1 && corrupt <= n + 1) : (corrupt == 1);
    chk(wr ? "R4 fail flag" : "R5 fail flag", {31'b0, got_fail}, {31'b0, exp_fail});
    chk("R6 read count", rd_cnt, (!wr && corrupt != 1) ? n : 0);
    @(negedge clk);
    chk("R8 done single pulse", {31'b0, done}, 32'd0);
    chk("R8 idle after poke", {31'b0, busy}, 32'd0);
  endtask

  task automatic run_reject(input int n);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_sel = 4'h3; req_addr = 16'h0042; req_count = CW'(n);
    @(negedge clk);
    req_valid = 0;
    chk("R7 reject done", {31'b0, done}, 32'd1);
    chk("R7 reject fail", {31'b0, fail}, 32'd1);
    chk("R7 reject busy", {31'b0, busy}, 32'd0);
    chk("R7 reject link", {31'b0, link_valid}, 32'd0);
    @(negedge clk);
    chk("R7 reject quiet", {30'b0, done, link_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_sel = 0; req_addr = 0; req_count = 0;
    link_ready = 0; link_rx = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset state", {28'b0, busy, done, link_valid, rd_valid}, 32'd0);
    run_xfer(1, 4'h0, 16'h0004, 1, 0, 0, 0);
    run_xfer(1, 4'hA, 16'hBEEF, 4, 0, 1, 0);
    run_xfer(0, 4'h2, 16'h0008, 3, 0, 0, 0);
    run_xfer(0, 4'h7, 16'hFF1F, 128, 0, 1, 0);
    run_xfer(1, 4'h1, 16'h1234, 5, 3, 0, 0);
    run_xfer(1, 4'h1, 16'h1235, 5, 6, 0, 0);
    run_xfer(1, 4'h4, 16'h0100, 2, 1, 0, 0);
    run_xfer(0, 4'h5, 16'h0200, 4, 1, 0, 0);
    run_xfer(0, 4'h6, 16'h0300, 4, 3, 1, 0);
    run_xfer(1, 4'hC, 16'h5555, 3, 0, 0, 1);
    run_xfer(1, 4'hF, 16'hFFFF, 128, 0, 0, 0);
    run_reject(0);
    run_reject(129);
    run_reject(255);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule